// File: doc/BRIEF.md
# Serial Slot-Select Writer

This block is the host-side controller that sends a 16-bit selection word over a three-wire serial link. The three wires are an active-low frame strobe, a serial clock and a serial data line. A client presents a word and pulses `start_i`. The block pulls the strobe low and shifts the word out most significant bit first. Each bit is captured at a rising edge of the serial clock. After the last bit the strobe returns high, and that rising strobe commits the selection at the far side.

The link needs minimum spacings around the strobe. One gap runs from the strobe falling to the first clock rise, and another runs from the last clock rise to the strobe rising. Every spacing in the frame is counted in system-clock cycles and set by a parameter. The defaults assume a 100 MHz system clock and give 120 ns and 290 ns for the two strobe gaps, with 40 ns clock half periods. `busy_o` covers the whole frame. A one-cycle `done_o` marks the cycle in which the strobe has returned high.

Top module: `slot_select_writer`

## Requirements
- R1: Out of reset and while idle, `strobe_n_o` and `sclk_o` are 1 and `busy_o` and `done_o` are 0. Asserting `rst_n` low at any time returns the block to this state.
- R2: When `start_i` is sampled high while idle, the strobe is low and `busy_o` is high in the following cycle.
- R3: A frame contains exactly WIDTH rising edges of `sclk_o` while the strobe is low. At the k-th rising edge `sdata_o` carries bit WIDTH-k of the word, so the most significant bit goes first.
- R4: The strobe falls exactly LEAD_CYC+HALF_CYC cycles before the first rising edge of `sclk_o`. The default is 12 cycles.
- R5: The strobe rises exactly HALF_CYC+TRAIL_CYC cycles after the last rising edge of `sclk_o`. The default is 29 cycles.
- R6: Every low phase of `sclk_o` lasts HALF_CYC cycles. Consecutive rising edges are 2*HALF_CYC cycles apart.
- R7: `sdata_o` changes only while `sclk_o` is low, and never in the same cycle that `sclk_o` falls. It holds steady across every rising edge.
- R8: `done_o` is high for exactly one cycle. That cycle is the first one with the strobe high again. The block is idle in the next cycle.
- R9: `start_i` has no effect while `busy_o` is high. The frame's bits and timing are unchanged, and a frame lasts LEAD_CYC+32*HALF_CYC+TRAIL_CYC cycles from strobe fall to strobe rise.
- R10: The word is taken from `value_i` in the cycle in which the start is accepted. Later changes to `value_i` do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to send `value_i` (accepted only when idle) |
| value_i | input | WIDTH | Selection word to send |
| busy_o | output | 1 | High from the accepted start through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| strobe_n_o | output | 1 | Active-low frame strobe |
| sclk_o | output | 1 | Serial clock, idle high |
| sdata_o | output | 1 | Serial data, captured on rising `sclk_o` |

## Verification
The bench sends a set of words: all zeros, all ones, alternating bits, a word with only its two outermost bits set, a mixed pattern and a small chassis/slot-like value. Between them these separate bit-order errors, stuck data and shifts by one place. Every frame is measured at the pins for edge count, both strobe gaps, phase lengths, data stability and done placement. `value_i` is scrambled right after acceptance, so a late capture of the word shows up. Some frames receive a second start in mid-frame to show it has no effect. Directed runs cover the reset state, reset during a frame and back-to-back frames.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_TRAIL = 3'd4,
    ST_DONE  = 3'd5
  } ssw_state_e;
endpackage

// File: rtl/ssw_timer.sv
module ssw_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = load_val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R6: without a reload the count falls by one each cycle
  assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ssw_shifter.sv
module ssw_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] value_i,
  input  logic             enter_low_i,
  output logic             sdata_o
);
  logic [WIDTH-1:0] sh_q, sh_d;
  logic             take_q;
  logic             data_q, data_d;

  always_comb begin
    sh_d   = sh_q;
    data_d = data_q;
    if (load_i) begin
      sh_d = value_i;
    end else if (take_q) begin
      data_d = sh_q[WIDTH-1];
      sh_d   = {sh_q[WIDTH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      data_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      data_q <= data_d;
      take_q <= enter_low_i;
    end
  end

  assign sdata_o = data_q;

  // R7: data moves only one cycle after a low phase has begun
  assert_data_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q != $past(data_q)) |-> $past(take_q));
endmodule

// File: rtl/ssw_fsm.sv
module ssw_fsm
  import ssw_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int LEAD_CYC  = 8,
  parameter int TRAIL_CYC = 25,
  parameter int HALF_CYC  = 4,
  parameter int TW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          accept_o,
  output logic          enter_low_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          strobe_n_o,
  output logic          sclk_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);
  localparam logic [TW-1:0] LEAD_LD  = TW'(LEAD_CYC - 1);
  localparam logic [TW-1:0] HALF_LD  = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] TRAIL_LD = TW'(TRAIL_CYC - 1);

  ssw_state_e       st_q, st_d;
  logic [CNT_W-1:0] bit_q, bit_d;

  always_comb begin
    st_d        = st_q;
    bit_d       = bit_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    accept_o    = 1'b0;
    enter_low_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d       = ST_LEAD;
        bit_d      = '0;
        accept_o   = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = LEAD_LD;
      end
      ST_LEAD: if (tmr_zero_i) begin
        st_d        = ST_LOW;
        enter_low_o = 1'b1;
        tmr_load_o  = 1'b1;
        tmr_val_o   = HALF_LD;
      end
      ST_LOW: if (tmr_zero_i) begin
        st_d       = ST_HIGH;
        tmr_load_o = 1'b1;
        tmr_val_o  = HALF_LD;
      end
      ST_HIGH: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        if (bit_q == LAST_BIT) begin
          st_d      = ST_TRAIL;
          tmr_val_o = TRAIL_LD;
        end else begin
          st_d        = ST_LOW;
          bit_d       = bit_q + 1'b1;
          enter_low_o = 1'b1;
          tmr_val_o   = HALF_LD;
        end
      end
      ST_TRAIL: if (tmr_zero_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign strobe_n_o = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign sclk_o     = (st_q != ST_LOW);

  // R8: completion lasts one cycle, right after the strobe was low
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (strobe_n_o && !$past(strobe_n_o)));
  // R2: a low strobe always belongs to a busy frame
  assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n_o |-> busy_o);
  // R9: a start during a frame never restarts the lead phase
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && st_q != ST_LEAD) |=> (st_q != ST_LEAD));
endmodule

// File: rtl/slot_select_writer.sv
module slot_select_writer #(
  parameter int WIDTH     = 16,
  parameter int LEAD_CYC  = 8,
  parameter int TRAIL_CYC = 25,
  parameter int HALF_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] value_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             strobe_n_o,
  output logic             sclk_o,
  output logic             sdata_o
);
  localparam int MAX_A = (LEAD_CYC > TRAIL_CYC) ? LEAD_CYC : TRAIL_CYC;
  localparam int MAX_C = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
  localparam int TW    = $clog2(MAX_C) + 1;

  logic          rst_s1_q, rst_s2_q;
  logic          tmr_load, tmr_zero, accept, enter_low;
  logic [TW-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  ssw_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_s2_q), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  ssw_fsm #(
    .WIDTH(WIDTH), .LEAD_CYC(LEAD_CYC), .TRAIL_CYC(TRAIL_CYC),
    .HALF_CYC(HALF_CYC), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s2_q), .start_i(start_i), .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .accept_o(accept),
    .enter_low_o(enter_low), .busy_o(busy_o), .done_o(done_o),
    .strobe_n_o(strobe_n_o), .sclk_o(sclk_o)
  );

  ssw_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_s2_q), .load_i(accept), .value_i(value_i),
    .enter_low_i(enter_low), .sdata_o(sdata_o)
  );

  // R7: data holds while the serial clock stays high
  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  // R1: the serial clock is high whenever the strobe is high
  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_s2_q)
    strobe_n_o |-> sclk_o);
endmodule

// File: tb/sim_slot_select_writer.sv
`timescale 1ns/1ps
module sim_slot_select_writer;
  localparam int W = 16, L = 8, T = 25, H = 4;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [W-1:0] value_i = '0;
  logic busy_o, done_o, strobe_n_o, sclk_o, sdata_o;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  slot_select_writer #(.WIDTH(W), .LEAD_CYC(L), .TRAIL_CYC(T), .HALF_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
    .busy_o(busy_o), .done_o(done_o), .strobe_n_o(strobe_n_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o)
  );

  // {inject mid-frame start, word sent, word expected at the far side}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 16'h0000, 16'h0000},
    {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'hA5C3, 16'hA5C3},
    {1'b0, 16'h8001, 16'h8001},
    {1'b1, 16'h0B09, 16'h0B09},
    {1'b0, 16'h5555, 16'h5555}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(strobe_n_o && sclk_o && !busy_o && !done_o, req,
        {strobe_n_o, sclk_o, busy_o, done_o}, 4'b1100);
  endtask

  task automatic run_frame(input logic [W-1:0] v, input logic inject, input logic [W-1:0] expv);
    logic [W-1:0] cap = '0;
    int nrise = 0, first_rise = -1, last_rise = -1, up_idx = -1, done_idx = -1;
    int done_cnt = 0, bad_gap = 0, bad_low = 0, bad_data = 0, low_len = 0;
    logic p_sclk = 1'b1, p_strobe = 1'b0, p_data;
    @(negedge clk); value_i = v; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; value_i = ~v;  // R10: word changed after acceptance
    chk(!strobe_n_o && busy_o, "R2", {strobe_n_o, busy_o}, 2'b01);
    p_data = sdata_o;
    for (int i = 0; i < 400; i++) begin
      if (i > 0) @(negedge clk);
      start_i = 1'b0;
      if (!sclk_o) low_len++;
      if (sclk_o && !p_sclk) begin
        cap = {cap[W-2:0], sdata_o};
        if (nrise > 0 && (i - last_rise) != 2*H) bad_gap++;
        if (nrise == 0) first_rise = i;
        if (low_len != H) bad_low++;
        last_rise = i; nrise++; low_len = 0;
      end
      if (sclk_o && p_sclk && sdata_o != p_data) bad_data++;
      if (!sclk_o && p_sclk && sdata_o != p_data) bad_data++;
      if (strobe_n_o && !p_strobe && up_idx < 0) up_idx = i;
      if (done_o) begin done_cnt++; if (done_idx < 0) done_idx = i; end
      p_sclk = sclk_o; p_strobe = strobe_n_o; p_data = sdata_o;
      if (inject && i == 40) begin start_i = 1'b1; value_i = 16'h1234; end
      if (done_idx >= 0 && i == done_idx + 1) break;
    end
    chk(cap == expv, "R3 word", cap, expv);
    chk(nrise == W, "R3 edges", nrise, W);
    chk(first_rise == L + H, "R4", first_rise, L + H);
    chk(up_idx - last_rise == H + T, "R5", up_idx - last_rise, H + T);
    chk(bad_low == 0 && bad_gap == 0, "R6", bad_low + bad_gap, 0);
    chk(bad_data == 0, "R7", bad_data, 0);
    chk(done_cnt == 1 && done_idx == up_idx, "R8", done_idx, up_idx);
    check_idle("R8 idle after done");
    if (inject) chk(up_idx == L + 32*H + T, "R9 length", up_idx, L + 32*H + T);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after reset");

    foreach (VEC[k]) run_frame(VEC[k][31:16], VEC[k][32], VEC[k][15:0]);

    // back-to-back frames, second starting as soon as idle
    run_frame(16'hC001, 1'b0, 16'hC001);
    run_frame(16'h3FFE, 1'b1, 16'h3FFE);

    // R1: reset during a frame returns to idle
    @(negedge clk); value_i = 16'hF0F0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy_o, "R1 mid-frame busy", busy_o, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1 reset mid-frame");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after second reset");
    run_frame(16'h1357, 1'b0, 16'h1357);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule